// File: doc/BRIEF.md
# Multiblock Parity Encoder for a 64B/66B Link

This block sits on the transmit path of a 64B/66B serial link, after the scrambler. It takes in the scrambled 64-bit payload blocks one per clock, through a valid/ready input. A marker flags the first block of each 32-block multiblock. Over the 2048 payload bits of every multiblock it computes a 26-bit cyclic parity word. The generator is the Fire-code polynomial x^26 + x^21 + x^17 + x^9 + x^4 + 1. The sync headers are not part of this computation.

The parity word of one multiblock goes out in the following multiblock. It travels as a 32-bit header stream, one stream bit per block. Each block leaves with its payload unchanged and a 2-bit sync header that encodes its stream bit. The stream also carries an end-of-extended-multiblock flag and a fixed pilot tail. The receiver uses the pilot to find multiblock boundaries.

The extended-multiblock length is an input, so the flag can be placed for lengths from 1 to 32 multiblocks. Each accepted block comes out one clock later.

Top module: `fec_mb_encoder`

## Requirements
- R1: While reset is asserted, `out_valid` is 0 and `par_word` is zero. `in_ready` reads 1 from the first clock edge after reset is released.
- R2: A block accepted in cycle t (`in_valid` and `in_ready` both 1) appears in cycle t+1 with `out_valid` = 1 and `out_data` equal to the accepted data.
- R3: Whenever `out_valid` is 1, `out_hdr` is 2'b10 for a stream bit of 1 and 2'b01 for a stream bit of 0. No other value is allowed.
- R4: An accepted block with `in_sob` = 1 takes header stream position 0. Any other accepted block takes the position after the previous accepted block, and position 31 wraps to 0.
- R5: Parity over a multiblock starts from an all-zero 26-bit state. It shifts in the 2048 payload bits, block 0 first and bit 63 of each block first, with the feedback mask 26'h0220211. `par_word` takes the result one cycle after position 31 is accepted. For example, a multiblock whose only set bit is bit 0 of block 31 gives 26'h0220211.
- R6: Stream positions 0 to 21 carry bits 25 down to 4 of `par_word`, as it stood when the block was accepted. That value belongs to the previous completed multiblock.
- R7: Stream position 22 carries the end-of-extended-multiblock flag.
- R8: Stream positions 23 to 26 carry bits 3 down to 0 of that same parity word.
- R9: Stream positions 27 to 31 carry 0,0,0,0,1, in that order.
- R10: The flag is 1 when the number of multiblocks completed since the last flagged one is at least `emb_len` - 1. An `emb_len` of 0 acts as 1. A multiblock counts as completed when its position 31 is accepted.
- R11: Until the first multiblock has completed, the parity positions of the stream carry zeros.
- R12: A multiblock cut short by a new `in_sob` before position 31 leaves `par_word` unchanged, and its partial parity is dropped.
- R13: In a cycle with no accepted block, the next cycle has `out_valid` = 0. Header position, parity state and `out_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can be accepted |
| in_sob | input | 1 | Block is position 0 of a multiblock |
| in_data | input | 64 | Scrambled payload block, bit 63 sent first |
| emb_len | input | 6 | Multiblocks per extended multiblock (1 to 32, 0 acts as 1) |
| out_valid | output | 1 | Output block present |
| out_data | output | 64 | Payload block, passed through |
| out_hdr | output | 2 | Sync header carrying the stream bit |
| par_word | output | 26 | Parity word of the last completed multiblock |

## Verification
The bench builds the block with its default parameters: 64-bit blocks, 32 blocks per multiblock and a 26-bit parity word. At these values the full header layout is reachable, including the wrap from position 31 to 0 and the single-bit parity case that yields the feedback mask. The extended-multiblock length is switched between 1, 3, 4 and 0. This exercises the flag at both the shortest and the longer periods, the zero-as-one rule, multiblocks truncated by an early start marker, and idle gaps between blocks.

// File: rtl/fec_mb_pkg.sv
package fec_mb_pkg;
  // degree of the Fire-code generator and its low-order feedback taps
  localparam int unsigned FEC_PAR_W = 26;
  localparam logic [FEC_PAR_W-1:0] FEC_POLY = 26'h0220211;
  // header stream layout, fixed for a 26-bit parity word
  localparam int unsigned HDR_LEN       = 32;
  localparam int unsigned HDR_EOEMB_POS = FEC_PAR_W - 4;
  localparam int unsigned HDR_PILOT_POS = FEC_PAR_W + 1;
  localparam logic [4:0]  HDR_PILOT_PAT = 5'b00001; // bit 4 goes out first
  localparam logic [1:0]  SH_ONE  = 2'b10;
  localparam logic [1:0]  SH_ZERO = 2'b01;
endpackage

// File: rtl/fec_par_calc.sv
module fec_par_calc #(
  parameter int unsigned BLK_W = 64,
  parameter int unsigned PAR_W = 26,
  parameter logic [PAR_W-1:0] POLY = 26'h0220211
) (
  input  logic [PAR_W-1:0] seed,
  input  logic [BLK_W-1:0] blk,
  output logic [PAR_W-1:0] res
);
  // one stage per payload bit, MSB of the block first
  logic [PAR_W-1:0] chain [BLK_W+1];

  assign chain[0] = seed;

  for (genvar i = 0; i < BLK_W; i++) begin : g_stage
    logic fb;
    assign fb = chain[i][PAR_W-1] ^ blk[BLK_W-1-i];
    assign chain[i+1] = {chain[i][PAR_W-2:0], 1'b0} ^ (POLY & {PAR_W{fb}});
  end

  assign res = chain[BLK_W];
endmodule

// File: rtl/fec_hdr_map.sv
module fec_hdr_map
  import fec_mb_pkg::*;
#(
  parameter int unsigned PAR_W = FEC_PAR_W,
  parameter int unsigned POS_W = 5
) (
  input  logic [POS_W-1:0] pos,
  input  logic [PAR_W-1:0] par,
  input  logic             eoemb,
  output logic             bit_o
);
  int unsigned        p;
  logic [PAR_W-1:0]   par_sh;
  logic [4:0]         pil_sh;

  always_comb begin
    p      = int'(pos);
    par_sh = '0;
    pil_sh = '0;
    bit_o  = 1'b0;
    if (p < HDR_EOEMB_POS) begin
      par_sh = par >> (PAR_W - 1 - p);
      bit_o  = par_sh[0];
    end else if (p == HDR_EOEMB_POS) begin
      bit_o  = eoemb;
    end else if (p < HDR_PILOT_POS) begin
      par_sh = par >> (PAR_W - p);
      bit_o  = par_sh[0];
    end else begin
      pil_sh = HDR_PILOT_PAT >> (HDR_LEN - 1 - p);
      bit_o  = pil_sh[0];
    end
  end
endmodule

// File: rtl/fec_mb_seq.sv
module fec_mb_seq #(
  parameter int unsigned MB_BLOCKS = 32,
  parameter int unsigned POS_W     = 5,
  parameter int unsigned MB_CNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                sob,
  input  logic [MB_CNT_W-1:0] emb_len,
  output logic [POS_W-1:0]    pos,
  output logic                last_blk,
  output logic                eoemb
);
  logic [POS_W-1:0]    blk_cnt_q, blk_cnt_d;
  logic [MB_CNT_W-1:0] mb_cnt_q, mb_cnt_d;
  logic [MB_CNT_W-1:0] len_eff;
  logic                blk_en, mb_en;

  always_comb begin
    pos      = sob ? '0 : blk_cnt_q;
    last_blk = (pos == POS_W'(MB_BLOCKS - 1));
    len_eff  = (emb_len == '0) ? MB_CNT_W'(1) : emb_len;
    eoemb    = (mb_cnt_q >= (len_eff - MB_CNT_W'(1)));
    blk_en   = accept;
    mb_en    = accept && last_blk;
    blk_cnt_d = last_blk ? '0 : (pos + POS_W'(1));
    mb_cnt_d  = eoemb ? '0 : (mb_cnt_q + MB_CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt_q <= '0;
      mb_cnt_q  <= '0;
    end else begin
      if (blk_en) blk_cnt_q <= blk_cnt_d;
      if (mb_en)  mb_cnt_q  <= mb_cnt_d;
    end
  end
endmodule

// File: rtl/fec_mb_encoder.sv
module fec_mb_encoder
  import fec_mb_pkg::*;
#(
  parameter int unsigned BLK_W     = 64,
  parameter int unsigned MB_BLOCKS = 32,
  parameter int unsigned PAR_W     = FEC_PAR_W,
  localparam int unsigned POS_W    = $clog2(MB_BLOCKS),
  localparam int unsigned MB_CNT_W = $clog2(MB_BLOCKS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sob,
  input  logic [BLK_W-1:0]    in_data,
  input  logic [MB_CNT_W-1:0] emb_len,
  output logic                out_valid,
  output logic [BLK_W-1:0]    out_data,
  output logic [1:0]          out_hdr,
  output logic [PAR_W-1:0]    par_word
);
  logic                accept;
  logic [POS_W-1:0]    pos;
  logic                last_blk, eoemb, hbit;
  logic [PAR_W-1:0]    seed, step_res;
  logic [PAR_W-1:0]    acc_q, acc_d, hold_q, hold_d;
  logic                rdy_q;
  logic                ov_q, ov_d;
  logic [BLK_W-1:0]    od_q, od_d;
  logic [1:0]          oh_q, oh_d;
  logic                acc_en, hold_en;

  assign accept = in_valid && rdy_q;

  fec_mb_seq #(
    .MB_BLOCKS (MB_BLOCKS),
    .POS_W     (POS_W),
    .MB_CNT_W  (MB_CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .sob      (in_sob),
    .emb_len  (emb_len),
    .pos      (pos),
    .last_blk (last_blk),
    .eoemb    (eoemb)
  );

  fec_par_calc #(
    .BLK_W (BLK_W),
    .PAR_W (PAR_W),
    .POLY  (FEC_POLY)
  ) u_calc (
    .seed (seed),
    .blk  (in_data),
    .res  (step_res)
  );

  fec_hdr_map #(
    .PAR_W (PAR_W),
    .POS_W (POS_W)
  ) u_map (
    .pos   (pos),
    .par   (hold_q),
    .eoemb (eoemb),
    .bit_o (hbit)
  );

  // next-state logic
  always_comb begin
    seed    = (pos == '0) ? '0 : acc_q;
    acc_en  = accept;
    hold_en = accept && last_blk;
    acc_d   = step_res;
    hold_d  = step_res;
    ov_d    = accept;
    od_d    = in_data;
    oh_d    = hbit ? SH_ONE : SH_ZERO;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      acc_q  <= '0;
      hold_q <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
      oh_q   <= SH_ZERO;
    end else begin
      rdy_q <= 1'b1;
      ov_q  <= ov_d;
      if (acc_en)  acc_q  <= acc_d;
      if (hold_en) hold_q <= hold_d;
      if (accept) begin
        od_q <= od_d;
        oh_q <= oh_d;
      end
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_hdr   = oh_q;
  assign par_word  = hold_q;
endmodule

// File: rtl/fec_mb_encoder_chk.sv
module fec_mb_encoder_chk #(
  parameter int unsigned BLK_W    = 64,
  parameter int unsigned PAR_W    = 26,
  parameter int unsigned MB_CNT_W = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [BLK_W-1:0]    in_data,
  input logic                out_valid,
  input logic [BLK_W-1:0]    out_data,
  input logic [1:0]          out_hdr,
  input logic [PAR_W-1:0]    par_word
);
  p_hdr_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hdr == 2'b10 || out_hdr == 2'b01));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_data_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data == $past(in_data)));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> (!out_valid && $stable(out_data)));

  p_par_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(par_word));
endmodule

bind fec_mb_encoder fec_mb_encoder_chk #(
  .BLK_W    (BLK_W),
  .PAR_W    (PAR_W),
  .MB_CNT_W (MB_CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_hdr   (out_hdr),
  .par_word  (par_word)
);

// File: tb/sim_fec_mb_encoder.sv
module sim_fec_mb_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sob = 1'b0;
  logic [63:0] in_data = '0;
  logic [5:0]  emb_len = 6'd1;
  logic        in_ready, out_valid;
  logic [63:0] out_data;
  logic [1:0]  out_hdr;
  logic [25:0] par_word;

  int checks = 0;
  int errors = 0;
  logic exp_v = 1'b0;
  logic run_mon = 1'b0;

  typedef struct {
    logic [63:0] d;
    logic [1:0]  h;
    logic [25:0] p;
    int          pos;
    string       ptag;
  } exp_t;
  exp_t q[$];

  int          m_cnt = 0;
  int          m_mb = 0;
  logic [25:0] m_acc = '0;
  logic [25:0] m_held = '0;
  string       cur_ptag = "R11";

  always #10 clk = ~clk;

  fec_mb_encoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sob(in_sob), .in_data(in_data), .emb_len(emb_len),
    .out_valid(out_valid), .out_data(out_data), .out_hdr(out_hdr),
    .par_word(par_word)
  );

  function automatic logic [25:0] ref_step(logic [25:0] s, logic [63:0] d);
    logic fb;
    for (int i = 63; i >= 0; i--) begin
      fb = s[25] ^ d[i];
      s  = {s[24:0], 1'b0};
      if (fb) s = s ^ 26'h0220211;
    end
    return s;
  endfunction

  function automatic logic ref_hbit(int p, logic [25:0] par, logic e);
    if (p < 22) return par[25-p];
    if (p == 22) return e;
    if (p < 27) return par[26-p];
    if (p < 31) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string hdr_tag(int p);
    if (p < 22) return "R6";
    if (p == 22) return "R7 R10";
    if (p < 27) return "R8";
    return "R9";
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // model of one accepted block, then drive it
  task automatic push_block(logic [63:0] d, logic sob);
    exp_t e;
    int   idx, len_eff;
    logic eo;
    @(posedge clk); #2;
    in_valid = 1'b1; in_data = d; in_sob = sob;
    idx = sob ? 0 : m_cnt;
    m_cnt = (idx + 1) % 32;
    len_eff = (emb_len == 0) ? 1 : int'(emb_len);
    eo = (m_mb >= len_eff - 1);
    e.d = d;
    e.h = ref_hbit(idx, m_held, eo) ? 2'b10 : 2'b01;
    e.pos = idx;
    m_acc = ref_step((idx == 0) ? 26'd0 : m_acc, d);
    if (idx == 31) begin
      m_held = m_acc;
      m_mb = eo ? 0 : m_mb + 1;
      cur_ptag = "R5";
    end
    e.p = m_held;
    e.ptag = cur_ptag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      in_valid = 1'b0;
      in_sob = $urandom_range(0, 1);
      in_data = {$urandom, $urandom};
    end
  endtask

  task automatic send_mb(int nblk, logic sob_first, bit rnd, bit gaps);
    for (int i = 0; i < nblk; i++) begin
      push_block(rnd ? {$urandom, $urandom} : 64'd0, (i == 0) && sob_first);
      if (gaps && $urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
    end
  endtask

  always @(posedge clk) exp_v <= rst_n && in_valid;

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (run_mon) begin
      check(out_valid === exp_v, exp_v ? "R2" : "R13", "out_valid", 64'(out_valid), 64'(exp_v));
      if (exp_v && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(out_data === e.d, "R2", "out_data", out_data, e.d);
        check(out_hdr === e.h, hdr_tag(e.pos), $sformatf("out_hdr pos %0d", e.pos),
              64'(out_hdr), 64'(e.h));
        check(par_word === e.p, e.ptag, "par_word", 64'(par_word), 64'(e.p));
      end
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid === 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
    check(par_word === 26'd0, "R1", "par_word in reset", 64'(par_word), 64'd0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(in_ready === 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
    run_mon = 1'b1;

    // R11: first multiblock, zeros in parity positions; R10 length 1 flags every one
    emb_len = 6'd1;
    send_mb(32, 1'b1, 1'b0, 1'b0);
    // R5 directed: single set bit at the very end
    for (int i = 0; i < 32; i++) push_block((i == 31) ? 64'd1 : 64'd0, i == 0);
    idle(1);
    @(negedge clk);
    check(par_word === 26'h0220211, "R5", "single-bit parity", 64'(par_word), 64'h0220211);

    // random multiblocks with gaps, length 3 (R10, R13); some without sob (R4 wrap)
    emb_len = 6'd3;
    for (int m = 0; m < 7; m++) send_mb(32, (m == 0) || ($urandom_range(0, 1) == 1), 1'b1, 1'b1);
    idle(2);

    // R12 and R4: truncated multiblock followed by restart
    send_mb(10, 1'b1, 1'b1, 1'b0);
    idle(1);
    @(negedge clk);
    check(par_word === m_held, "R12", "par after short mb", 64'(par_word), 64'(m_held));
    send_mb(32, 1'b1, 1'b1, 1'b0);

    // length 4 and length 0 (acts as 1)
    emb_len = 6'd4;
    for (int m = 0; m < 5; m++) send_mb(32, 1'b1, 1'b1, 1'b1);
    idle(1);
    emb_len = 6'd0;
    for (int m = 0; m < 3; m++) send_mb(32, 1'b0, 1'b1, 1'b0);
    idle(4);
    @(negedge clk);
    check(q.size() == 0, "R2", "pending outputs", 64'(q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule